// File: doc/BRIEF.md
# Receive Frame Acceptance Filter

This block sits in the receive path between a byte-wide MAC receive stream and the write port of a receive buffer. Each frame arrives as a run of `rx_valid` bytes followed by a single `rx_eof` strobe that carries the frame's short, alignment and CRC error flags. Bytes go to the buffer as they arrive, at consecutive addresses. At the end of the frame the block decides whether to keep the frame. A kept frame moves the committed write pointer forward. A dropped frame rolls the write pointer back to where the frame started, so no partial data stays in the buffer.

The decision combines three checks. The first is a destination-address compare against a programmable 48-bit node address, using one of four match policies, with an option to compare only the leading 40 bits. The second is a length window whose lower bound can be relaxed for short frames. The third is an error screen that can be switched off so that damaged frames are kept. A frame carrying a selectable length/type value can also raise a one-cycle remote-reset request. A byte-wide mode/status register holds the options and reports whether the buffer has been fully drained.

Top module: `rx_accept_filter`

## Requirements
- R1: After reset, `reg_rdata` reads 0x41: test bit 0, empty bit 1, all option bits 0, and match mode 01.
- R2: Register layout is bit 7 test, bit 6 empty, bit 5 keep-bad, bit 4 short-address, bit 3 short-frame enable, bit 2 remote-reset enable, and bits 1:0 match mode. A write sets only bits 5:0. Bit 7 always reads 0, and a 1 written to it is ignored. Writes to bit 6 have no effect.
- R3: Bit 6 reads 1 exactly when the committed write pointer equals `buf_rd_ptr`. The committed pointer changes only at `rx_eof`.
- R4: Every received byte among the first 2048 of a frame is written in the same cycle on `buf_wr_en`/`buf_wr_data`, at consecutive addresses. After a rejected frame, the next frame starts at the address where the rejected one started. After an accepted frame, the next frame continues from the address just past it. `rx_eof` never coincides with `rx_valid`.
- R5: When keep-bad is 0, a frame with any of the short, alignment or CRC flags set is rejected. When keep-bad is 1, such flags do not cause rejection.
- R6: When short-address is 0, a node-address hit needs all 6 destination bytes to equal `node_id`, with `node_id[47:40]` as the first byte on the wire. When short-address is 1, only the first 5 bytes are compared.
- R7: Match mode 00 rejects every frame. Mode 01 accepts a node-address hit or the all-ones broadcast address. Mode 10 also accepts any address whose first byte has bit 0 set. Mode 11 accepts every destination. Modes 01 and 10 need at least 6 bytes.
- R8: The frame length is the number of `rx_valid` bytes. With keep-bad 0, the length must exceed 60 (short-frame enable 0) or exceed 6 (enable 1), and it must be below 2048. At 2048 bytes or more, only the first 2048 bytes are written and the frame is rejected.
- R9: When keep-bad is 1, the short-frame enable bit has no effect and any length from 1 to 2047 passes the length check.
- R10: `remote_reset_req` pulses for one cycle, together with `frame_accept`, when remote-reset enable is 1, the frame is accepted, and bytes 12 and 13 are 0x09 and 0x00. It stays low when the enable is 0 or the value differs.
- R11: Exactly one of `frame_accept` and `frame_reject` pulses, in the cycle after `rx_eof`. Neither pulses at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Write strobe for the mode/status register |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| node_id | input | 48 | Station address; bits 47:40 are compared with the first byte |
| rx_valid | input | 1 | A frame byte is present on `rx_data` |
| rx_data | input | 8 | Frame byte |
| rx_eof | input | 1 | End-of-frame strobe, one cycle, with no byte |
| rx_err_short | input | 1 | Short-frame error flag, valid with `rx_eof` |
| rx_err_align | input | 1 | Alignment error flag, valid with `rx_eof` |
| rx_err_crc | input | 1 | CRC error flag, valid with `rx_eof` |
| buf_rd_ptr | input | 10 | Reader's position in the buffer |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_wr_addr | output | 10 | Buffer write address |
| buf_wr_data | output | 8 | Buffer write data |
| frame_accept | output | 1 | One-cycle pulse: frame kept |
| frame_reject | output | 1 | One-cycle pulse: frame dropped |
| remote_reset_req | output | 1 | One-cycle remote-reset request |

## Verification
The hardest case to reach is the over-length frame. It needs more than two thousand bytes in a row, it must stop writing after exactly 2048 bytes, and it must then roll the pointer back across the whole span. The stimulus sends frames of 2047, 2048 and 2050 bytes back to back. A second case is the boundary between keep-bad and the short-frame enable: a 10-byte frame is sent with the enable both set and cleared while keep-bad is on, so any leak of the enable changes the verdict. The reference model tracks the committed and running pointers independently, so a wrong rollback shows up as an address miscompare on the following frame.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

   typedef enum logic [1:0] {
      AM_NONE       = 2'b00,
      AM_NODE_BC    = 2'b01,
      AM_NODE_BC_MC = 2'b10,
      AM_ALL        = 2'b11
   } am_mode_e;

   // Bit order matches register bits 5:0
   typedef struct packed {
      logic     keep_bad;
      logic     addr_short;
      logic     short_en;
      logic     rr_en;
      am_mode_e am;
   } mode_cfg_t;

   localparam int CFG_W      = $bits(mode_cfg_t);
   localparam int REG_W      = 8;
   localparam int EMPTY_BIT  = 6;
   localparam int TEST_BIT   = 7;

endpackage

// File: rtl/rxf_mode_reg.sv
module rxf_mode_reg
   import rxf_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wdata,
   input  logic              buf_empty,
   output logic [REG_W-1:0]  rdata,
   output mode_cfg_t         cfg
);

   localparam mode_cfg_t CFG_RST = '{keep_bad: 1'b0, addr_short: 1'b0,
                                     short_en: 1'b0, rr_en: 1'b0,
                                     am: AM_NODE_BC};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cfg <= CFG_RST;
      else if (wr_en)
         cfg <= mode_cfg_t'(wdata[CFG_W-1:0]);
   end

   // Test bit reads zero; empty bit is live status
   always_comb begin
      rdata                = '0;
      rdata[CFG_W-1:0]     = cfg;
      rdata[EMPTY_BIT]     = buf_empty;
      rdata[TEST_BIT]      = 1'b0;
   end

   p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(cfg));

endmodule

// File: rtl/rxf_frame_track.sv
module rxf_frame_track #(
   parameter int DW       = 8,
   parameter int MAX_LEN  = 2048,
   parameter int TYPE_POS = 12,
   parameter int LEN_W    = $clog2(MAX_LEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [DW-1:0]     rx_data,
   input  logic              rx_eof,
   output logic [LEN_W-1:0]  len,
   output logic [2*DW-1:0]   type_field
);

   localparam logic [LEN_W-1:0] LEN_CAP  = LEN_W'(MAX_LEN);
   localparam logic [LEN_W-1:0] TYPE_HI  = LEN_W'(TYPE_POS);
   localparam logic [LEN_W-1:0] TYPE_LO  = LEN_W'(TYPE_POS + 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         len <= '0;
      else if (rx_eof)
         len <= '0;
      else if (rx_valid && len != LEN_CAP)
         len <= len + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         type_field <= '0;
      else if (rx_valid && len == TYPE_HI)
         type_field[2*DW-1:DW] <= rx_data;
      else if (rx_valid && len == TYPE_LO)
         type_field[DW-1:0] <= rx_data;
   end

   p_len_capped_r8: assert property (@(posedge clk) disable iff (!rst_n)
      len <= LEN_CAP);

endmodule

// File: rtl/rxf_addr_match.sv
module rxf_addr_match
   import rxf_pkg::*;
#(
   parameter int DW        = 8,
   parameter int MAC_BYTES = 6,
   parameter int CMP_SHORT = 5,
   parameter int LEN_W     = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    rx_valid,
   input  logic [DW-1:0]           rx_data,
   input  logic                    rx_eof,
   input  logic [LEN_W-1:0]        len,
   input  logic [MAC_BYTES*DW-1:0] node_id,
   input  logic                    addr_short,
   input  am_mode_e                am,
   output logic                    addr_hit
);

   logic [MAC_BYTES-1:0] byte_mis;
   logic [MAC_BYTES-1:0] byte_ones;
   logic [MAC_BYTES-1:0] cmp_mask;
   logic                 group_bit;
   logic                 full_addr;
   logic                 node_hit;
   logic                 bcast_hit;
   logic                 mcast_hit;

   // One compare slot per destination byte; first wire byte is node_id MSB
   for (genvar i = 0; i < MAC_BYTES; i++) begin : g_byte
      localparam logic [LEN_W-1:0] IDX = LEN_W'(i);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            byte_mis[i]  <= 1'b0;
            byte_ones[i] <= 1'b0;
         end else if (rx_eof) begin
            byte_mis[i]  <= 1'b0;
            byte_ones[i] <= 1'b0;
         end else if (rx_valid && len == IDX) begin
            byte_mis[i]  <= (rx_data != node_id[(MAC_BYTES-1-i)*DW +: DW]);
            byte_ones[i] <= (rx_data == {DW{1'b1}});
         end
      end
      if (i < CMP_SHORT) begin : g_always
         assign cmp_mask[i] = 1'b1;
      end else begin : g_full_only
         assign cmp_mask[i] = !addr_short;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         group_bit <= 1'b0;
      else if (rx_eof)
         group_bit <= 1'b0;
      else if (rx_valid && len == '0)
         group_bit <= rx_data[0];
   end

   assign full_addr = (len >= LEN_W'(MAC_BYTES));
   assign node_hit  = full_addr && !(|(byte_mis & cmp_mask));
   assign bcast_hit = full_addr && (&byte_ones);
   assign mcast_hit = full_addr && group_bit;

   always_comb begin
      unique case (am)
         AM_NONE:       addr_hit = 1'b0;
         AM_NODE_BC:    addr_hit = node_hit || bcast_hit;
         AM_NODE_BC_MC: addr_hit = node_hit || bcast_hit || mcast_hit;
         default:       addr_hit = 1'b1;
      endcase
   end

   p_bcast_is_group_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bcast_hit |-> group_bit);

endmodule

// File: rtl/rxf_buf_wr.sv
module rxf_buf_wr #(
   parameter int DW      = 8,
   parameter int AW      = 10,
   parameter int MAX_LEN = 2048,
   parameter int LEN_W   = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [DW-1:0]     rx_data,
   input  logic              rx_eof,
   input  logic [LEN_W-1:0]  len,
   input  logic              keep,
   input  logic [AW-1:0]     rd_ptr,
   output logic              wr_en,
   output logic [AW-1:0]     wr_addr,
   output logic [DW-1:0]     wr_data,
   output logic              empty
);

   localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_LEN);

   logic [AW-1:0] wr_ptr;
   logic [AW-1:0] commit_ptr;

   assign wr_en   = rx_valid && (len < LEN_CAP);
   assign wr_addr = wr_ptr;
   assign wr_data = rx_data;
   assign empty   = (commit_ptr == rd_ptr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr     <= '0;
         commit_ptr <= '0;
      end else if (rx_eof) begin
         if (keep)
            commit_ptr <= wr_ptr;
         else
            wr_ptr     <= commit_ptr;
      end else if (wr_en) begin
         wr_ptr <= wr_ptr + 1'b1;
      end
   end

   p_commit_only_eof_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_eof |=> $stable(commit_ptr));

   p_wr_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (len < LEN_CAP));

   p_eof_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_eof |=> (wr_ptr == commit_ptr));

endmodule

// File: rtl/rx_accept_filter.sv
module rx_accept_filter
   import rxf_pkg::*;
#(
   parameter int          DW        = 8,
   parameter int          BUF_AW    = 10,
   parameter int          MAC_BYTES = 6,
   parameter int          CMP_SHORT = 5,
   parameter int          MAX_LEN   = 2048,
   parameter int          MIN_LONG  = 60,
   parameter int          MIN_SHORT = 6,
   parameter int          TYPE_POS  = 12,
   parameter logic [15:0] RR_TYPE   = 16'h0900
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    reg_wr_en,
   input  logic [7:0]              reg_wdata,
   output logic [7:0]              reg_rdata,
   input  logic [47:0]             node_id,
   input  logic                    rx_valid,
   input  logic [7:0]              rx_data,
   input  logic                    rx_eof,
   input  logic                    rx_err_short,
   input  logic                    rx_err_align,
   input  logic                    rx_err_crc,
   input  logic [BUF_AW-1:0]       buf_rd_ptr,
   output logic                    buf_wr_en,
   output logic [BUF_AW-1:0]       buf_wr_addr,
   output logic [7:0]              buf_wr_data,
   output logic                    frame_accept,
   output logic                    frame_reject,
   output logic                    remote_reset_req
);

   localparam int LEN_W = $clog2(MAX_LEN + 1);

   // Elaboration-time parameter checks
   if (DW != 8) begin : g_chk_dw
      $error("rx_accept_filter: DW must be 8");
   end
   if (MAC_BYTES * DW != 48) begin : g_chk_mac
      $error("rx_accept_filter: node address must be 48 bits");
   end
   if (CMP_SHORT < 1 || CMP_SHORT >= MAC_BYTES) begin : g_chk_cmp
      $error("rx_accept_filter: CMP_SHORT out of range");
   end
   if (MIN_SHORT >= MIN_LONG || MIN_LONG >= MAX_LEN) begin : g_chk_len
      $error("rx_accept_filter: length bounds inconsistent");
   end
   if (TYPE_POS + 2 > MAX_LEN) begin : g_chk_type
      $error("rx_accept_filter: TYPE_POS beyond frame limit");
   end

   mode_cfg_t          cfg;
   logic               buf_empty;
   logic [LEN_W-1:0]   len;
   logic [15:0]        type_field;
   logic               addr_hit;
   logic               any_err;
   logic               lo_ok;
   logic               hi_ok;
   logic               err_ok;
   logic               keep;
   logic               rr_hit;
   logic [LEN_W-1:0]   min_len;

   rxf_mode_reg u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr_en),
      .wdata     (reg_wdata),
      .buf_empty (buf_empty),
      .rdata     (reg_rdata),
      .cfg       (cfg)
   );

   rxf_frame_track #(
      .DW       (DW),
      .MAX_LEN  (MAX_LEN),
      .TYPE_POS (TYPE_POS),
      .LEN_W    (LEN_W)
   ) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_valid   (rx_valid),
      .rx_data    (rx_data),
      .rx_eof     (rx_eof),
      .len        (len),
      .type_field (type_field)
   );

   rxf_addr_match #(
      .DW        (DW),
      .MAC_BYTES (MAC_BYTES),
      .CMP_SHORT (CMP_SHORT),
      .LEN_W     (LEN_W)
   ) u_match (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_valid   (rx_valid),
      .rx_data    (rx_data),
      .rx_eof     (rx_eof),
      .len        (len),
      .node_id    (node_id),
      .addr_short (cfg.addr_short),
      .am         (cfg.am),
      .addr_hit   (addr_hit)
   );

   rxf_buf_wr #(
      .DW      (DW),
      .AW      (BUF_AW),
      .MAX_LEN (MAX_LEN),
      .LEN_W   (LEN_W)
   ) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_valid (rx_valid),
      .rx_data  (rx_data),
      .rx_eof   (rx_eof),
      .len      (len),
      .keep     (keep),
      .rd_ptr   (buf_rd_ptr),
      .wr_en    (buf_wr_en),
      .wr_addr  (buf_wr_addr),
      .wr_data  (buf_wr_data),
      .empty    (buf_empty)
   );

   // End-of-frame verdict
   assign any_err = rx_err_short || rx_err_align || rx_err_crc;
   assign min_len = cfg.short_en ? LEN_W'(MIN_SHORT) : LEN_W'(MIN_LONG);
   assign lo_ok   = cfg.keep_bad ? (len != '0) : (len > min_len);
   assign hi_ok   = (len < LEN_W'(MAX_LEN));
   assign err_ok  = cfg.keep_bad || !any_err;
   assign keep    = addr_hit && lo_ok && hi_ok && err_ok;
   assign rr_hit  = cfg.rr_en && (len >= LEN_W'(TYPE_POS + 2))
                    && (type_field == RR_TYPE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_accept     <= 1'b0;
         frame_reject     <= 1'b0;
         remote_reset_req <= 1'b0;
      end else begin
         frame_accept     <= rx_eof && keep;
         frame_reject     <= rx_eof && !keep;
         remote_reset_req <= rx_eof && keep && rr_hit;
      end
   end

   p_one_verdict_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({frame_accept, frame_reject}));

   p_verdict_after_eof_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_accept || frame_reject) |-> $past(rx_eof));

   p_rr_with_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      remote_reset_req |-> frame_accept);

   p_eof_no_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_eof |-> !rx_valid);

   p_test_bit_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en && reg_wdata[7] |=> !reg_rdata[7]);

endmodule

// File: tb/rx_accept_filter_tb.sv
`timescale 1ns/1ps
module rx_accept_filter_tb;

   localparam logic [47:0] NODE = 48'h02_11_22_33_44_55;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_eof = 1'b0;
   logic        e_short = 1'b0, e_align = 1'b0, e_crc = 1'b0;
   logic [9:0]  rd_ptr = '0;
   logic        buf_wr_en;
   logic [9:0]  buf_wr_addr;
   logic [7:0]  buf_wr_data;
   logic        frame_accept, frame_reject, remote_reset_req;

   always #4 clk = ~clk;

   rx_accept_filter u_dut (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .node_id(NODE),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_eof(rx_eof),
      .rx_err_short(e_short), .rx_err_align(e_align), .rx_err_crc(e_crc),
      .buf_rd_ptr(rd_ptr),
      .buf_wr_en(buf_wr_en), .buf_wr_addr(buf_wr_addr), .buf_wr_data(buf_wr_data),
      .frame_accept(frame_accept), .frame_reject(frame_reject),
      .remote_reset_req(remote_reset_req)
   );

   // Reference model state
   int          n_vec = 0;
   int          n_bad = 0;
   string       cur_req = "R1";
   logic [5:0]  m_reg = 6'b00_0001;
   logic [9:0]  m_wr = '0;
   logic [9:0]  m_commit = '0;
   int          m_len = 0;
   logic [7:0]  mq[$];
   logic        x_acc = 1'b0, x_rej = 1'b0, x_rr = 1'b0;
   logic [7:0]  sq[$];

   task automatic fail_msg(string req, string what, longint act, longint exp);
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
   endtask

   function automatic bit model_keep();
      bit kb = m_reg[5], as = m_reg[4], se = m_reg[3];
      logic [1:0] md = m_reg[1:0];
      bit addr = 0, node = 1, bc = 1, lok, eok;
      int ncmp = as ? 5 : 6;
      if (m_len >= 6) begin
         for (int i = 0; i < 6; i++) begin
            if (i < ncmp && mq[i] != NODE[47-8*i -: 8]) node = 0;
            if (mq[i] != 8'hFF) bc = 0;
         end
      end else begin
         node = 0; bc = 0;
      end
      case (md)
         2'b00: addr = 0;
         2'b01: addr = node || bc;
         2'b10: addr = node || bc || (m_len >= 6 && mq[0][0]);
         default: addr = 1;
      endcase
      if (kb) lok = (m_len >= 1) && (m_len <= 2047);
      else    lok = (m_len > (se ? 6 : 60)) && (m_len <= 2047);
      eok = kb || !(e_short || e_align || e_crc);
      return addr && lok && eok;
   endfunction

   task automatic step();
      bit xw;
      #1;
      n_vec++;
      xw = rx_valid && (m_len < 2048);
      if (buf_wr_en !== xw) fail_msg("R4", "buf_wr_en", buf_wr_en, xw);
      else if (xw && buf_wr_addr !== m_wr) fail_msg(cur_req, "buf_wr_addr", buf_wr_addr, m_wr);
      else if (xw && buf_wr_data !== rx_data) fail_msg("R4", "buf_wr_data", buf_wr_data, rx_data);
      if (frame_accept !== x_acc) fail_msg(cur_req, "frame_accept", frame_accept, x_acc);
      if (frame_reject !== x_rej) fail_msg(cur_req, "frame_reject", frame_reject, x_rej);
      if (remote_reset_req !== x_rr) fail_msg("R10", "remote_reset_req", remote_reset_req, x_rr);
      if (reg_rdata !== {1'b0, (m_commit == rd_ptr), m_reg})
         fail_msg("R3", "reg_rdata", reg_rdata, {1'b0, (m_commit == rd_ptr), m_reg});
      @(posedge clk);
      x_acc = 0; x_rej = 0; x_rr = 0;
      if (rx_eof) begin
         bit k = model_keep();
         x_acc = k; x_rej = !k;
         x_rr = k && m_reg[2] && m_len >= 14 && mq[12] == 8'h09 && mq[13] == 8'h00;
         if (k) m_commit = m_wr; else m_wr = m_commit;
         mq.delete(); m_len = 0;
      end else if (rx_valid && m_len < 2048) begin
         mq.push_back(rx_data); m_wr = m_wr + 1'b1; m_len++;
      end
      if (reg_wr_en) m_reg = reg_wdata[5:0];
      @(negedge clk);
   endtask

   task automatic reg_write(logic [7:0] v);
      reg_wr_en = 1; reg_wdata = v; step();
      reg_wr_en = 0; reg_wdata = '0;
   endtask

   task automatic set_mode(bit kb, bit as, bit se, bit rr, logic [1:0] md);
      reg_write({2'b00, kb, as, se, rr, md});
   endtask

   task automatic build(logic [47:0] dst, logic [15:0] ty, int n);
      sq.delete();
      for (int i = 0; i < n; i++) begin
         if (i < 6)       sq.push_back(dst[47-8*i -: 8]);
         else if (i == 12) sq.push_back(ty[15:8]);
         else if (i == 13) sq.push_back(ty[7:0]);
         else             sq.push_back(8'(i * 7 + 3));
      end
   endtask

   task automatic send(string req, bit s, bit a, bit c, bit exp_keep);
      cur_req = req;
      foreach (sq[i]) begin
         rx_valid = 1; rx_data = sq[i]; step();
      end
      rx_valid = 0; rx_data = '0;
      rx_eof = 1; e_short = s; e_align = a; e_crc = c;
      step();
      rx_eof = 0; e_short = 0; e_align = 0; e_crc = 0;
      // Bench-level verdict intent check, independent of the model
      n_vec++;
      if (frame_accept !== exp_keep) fail_msg(req, "intended verdict", frame_accept, exp_keep);
      step();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      n_vec++;
      if (reg_rdata !== 8'h41) fail_msg("R1", "reset reg", reg_rdata, 8'h41);
      rst_n = 1;
      @(negedge clk);
      cur_req = "R1"; step();

      // R2: test bit and empty bit not writable
      cur_req = "R2"; reg_write(8'hFF); step();
      n_vec++;
      if (reg_rdata !== 8'h7F) fail_msg("R2", "after 0xFF write", reg_rdata, 8'h7F);
      reg_write(8'h80); step();
      n_vec++;
      if (reg_rdata !== 8'h40) fail_msg("R2", "after 0x80 write", reg_rdata, 8'h40);

      // R7 / R4 / R3: node frame accepted in mode 01
      set_mode(0, 0, 0, 0, 2'b01);
      build(NODE, 16'h0800, 64); send("R7", 0, 0, 0, 1);
      n_vec++;
      if (reg_rdata[6] !== 1'b0) fail_msg("R3", "empty after keep", reg_rdata[6], 0);
      rd_ptr = 10'd64; step();
      n_vec++;
      if (reg_rdata[6] !== 1'b1) fail_msg("R3", "empty after drain", reg_rdata[6], 1);
      build(48'h0A_BB_CC_DD_EE_FF, 16'h0800, 64); send("R4", 0, 0, 0, 0);
      build(48'hFF_FF_FF_FF_FF_FF, 16'h0800, 64); send("R7", 0, 0, 0, 1);
      rd_ptr = 10'd128;
      build(48'h01_00_5E_00_00_01, 16'h0800, 64); send("R7", 0, 0, 0, 0);
      set_mode(0, 0, 0, 0, 2'b10);
      build(48'h01_00_5E_00_00_01, 16'h0800, 64); send("R7", 0, 0, 0, 1);
      set_mode(0, 0, 0, 0, 2'b00);
      build(NODE, 16'h0800, 64); send("R7", 0, 0, 0, 0);
      set_mode(0, 0, 0, 0, 2'b11);
      build(48'h0A_BB_CC_DD_EE_FF, 16'h0800, 64); send("R7", 0, 0, 0, 1);

      // R6: last address byte differs
      set_mode(0, 0, 0, 0, 2'b01);
      build(48'h02_11_22_33_44_99, 16'h0800, 64); send("R6", 0, 0, 0, 0);
      set_mode(0, 1, 0, 0, 2'b01);
      build(48'h02_11_22_33_44_99, 16'h0800, 64); send("R6", 0, 0, 0, 1);
      build(48'h02_11_22_33_77_55, 16'h0800, 64); send("R6", 0, 0, 0, 0);

      // R8: length bounds
      set_mode(0, 0, 0, 0, 2'b01);
      build(NODE, 16'h0800, 60); send("R8", 0, 0, 0, 0);
      build(NODE, 16'h0800, 61); send("R8", 0, 0, 0, 1);
      set_mode(0, 0, 1, 0, 2'b01);
      build(NODE, 16'h0800, 6); send("R8", 0, 0, 0, 0);
      build(NODE, 16'h0800, 7); send("R8", 0, 0, 0, 1);
      build(NODE, 16'h0800, 2047); send("R8", 0, 0, 0, 1);
      build(NODE, 16'h0800, 2048); send("R8", 0, 0, 0, 0);
      build(NODE, 16'h0800, 2050); send("R8", 0, 0, 0, 0);

      // R5: error screen
      set_mode(0, 0, 0, 0, 2'b01);
      build(NODE, 16'h0800, 64); send("R5", 0, 0, 1, 0);
      build(NODE, 16'h0800, 64); send("R5", 0, 1, 0, 0);
      build(NODE, 16'h0800, 64); send("R5", 1, 0, 0, 0);
      set_mode(1, 0, 0, 0, 2'b01);
      build(NODE, 16'h0800, 64); send("R5", 1, 1, 1, 1);

      // R9: short-frame enable ignored under keep-bad
      set_mode(1, 0, 0, 0, 2'b01);
      build(NODE, 16'h0800, 10); send("R9", 0, 0, 0, 1);
      set_mode(1, 0, 1, 0, 2'b01);
      build(NODE, 16'h0800, 10); send("R9", 0, 0, 0, 1);
      set_mode(1, 0, 1, 0, 2'b11);
      build(NODE, 16'h0800, 2); send("R9", 0, 0, 0, 1);

      // R10: remote reset
      set_mode(0, 0, 0, 1, 2'b01);
      build(NODE, 16'h0900, 64); send("R10", 0, 0, 0, 1);
      build(NODE, 16'h0800, 64); send("R10", 0, 0, 0, 1);
      build(48'h0A_BB_CC_DD_EE_FF, 16'h0900, 64); send("R10", 0, 0, 0, 0);
      set_mode(0, 0, 0, 0, 2'b01);
      build(NODE, 16'h0900, 64); send("R10", 0, 0, 0, 1);

      // R11: idle cycles produce no verdict
      cur_req = "R11";
      repeat (5) step();

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule